// File: doc/BRIEF.md
# Configurable Input Noise Filter

This block conditions one asynchronous input pin before a timer channel acts on it. The pin is first brought into the clock domain by a chain of synchroniser flops. The synchronised level is then qualified according to one of three rules that can be changed at run time, and only a qualified change reaches the filtered output. Short glitches that do not meet the active rule never appear at the output.

Sampling runs off a sample-enable strobe that a shared prescaler elsewhere on the chip produces. The two sample-counting modes take one sample per strobe. In these modes the level changes once two, or three, successive samples agree on a level different from the current output. The continuous mode counts strobes while the synchronised input differs from the output. If the input falls back to the output level on any clock, the count restarts. The output flips when the count reaches a parameterised window length of 1 to 15 strobes, which is held in a 4-bit counter. The block pulses a rising-edge or falling-edge strobe for one clock in the cycle where the filtered level changes.

Top module: `pin_qual_filter`

## Requirements
- R1: `pin_raw` passes through SYNC_STAGES (default 2) flops before qualification. A pin change is first seen by the qualifier SYNC_STAGES clock edges after the edge that captures it.
- R2: With mode 2'b00 (two-sample), `level` takes a new value only after two successive strobe samples both equal that value. A level held for a single sample is rejected.
- R3: With mode 2'b01 (three-sample), `level` takes a new value only after three successive strobe samples all equal that value. Two agreeing samples are not enough.
- R4: With mode 2'b10 (continuous), `level` flips once the synchronised input has differed from `level` on every clock across RUN_STROBES (default 6) strobes. Any clock where it matches `level` restarts the count from zero.
- R5: On clocks where `sample_en` is low, no sample is taken and no count advances, so `level` holds.
- R6: While `rst_n` is low at a clock edge, `level`, `rise_pulse`, `fall_pulse`, the synchroniser, the sample history and the continuous count are all cleared to zero.
- R7: `rise_pulse` (resp. `fall_pulse`) is high for exactly one clock, in the cycle in which `level` has just become 1 (resp. 0). The two pulses are never high together.
- R8: A clock on which `mode` differs from its value on the previous clock clears the sample history and the continuous count and takes no sample. `level` is left as it was.
- R9: Mode 2'b11 qualifies exactly as mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Sample strobe, one clock wide per sample |
| pin_raw | input | 1 | Asynchronous raw input pin |
| mode | input | 2 | 00 two-sample, 01 three-sample, 10 continuous, 11 as 00 |
| level | output | 1 | Filtered level |
| rise_pulse | output | 1 | One-clock pulse on a 0-to-1 change of `level` |
| fall_pulse | output | 1 | One-clock pulse on a 1-to-0 change of `level` |

## Verification
Some properties are checked on every cycle: the pulses are exclusive and match the change of `level`, `level` moves only after a strobe cycle, `level` holds across a mode change, and the continuous count stays below its window. Other behaviour shows only in the bench scenarios: the number of agreeing samples each mode needs, rejection of glitches one sample shorter than the rule, restart of the continuous count, and loss of history at a mode switch. The bench compares the outputs against a cycle model on every clock.

// File: rtl/pqf_pkg.sv
// Shared encodings for the pin qualification filter.
// Assumes the mode field is exactly two bits wide.
package pqf_pkg;
    typedef enum logic [1:0] {
        PQF_TWO   = 2'b00,
        PQF_THREE = 2'b01,
        PQF_RUN   = 2'b10,
        PQF_SPARE = 2'b11
    } pqf_mode_e;
endpackage

// File: rtl/pqf_sync.sv
// Multi-flop synchroniser for one asynchronous bit.
// Assumes STAGES >= 2; output is the last flop of the chain.
module pqf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw bit through the flop chain, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pqf_sample_qual.sv
// Sample-counting qualifier: keeps a history of strobe samples and asks
// for a level flip once the required number of samples agree.
// Assumes HIST_DEPTH >= 2 so the three-sample rule can be met.
module pqf_sample_qual
    import pqf_pkg::*;
#(
    parameter int HIST_DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sample_en,
    input  logic      sync_in,
    input  logic      cur_level,
    input  logic      clear,
    input  pqf_mode_e mode,
    output logic      want_flip
);
    localparam int VW = $clog2(HIST_DEPTH + 1);

    logic [HIST_DEPTH-1:0] hist;
    logic [VW-1:0]         valid;
    logic [VW-1:0]         need;
    logic                  agree;

    // Shift a new sample into the history on each strobe.
    generate
        for (genvar i = 0; i < HIST_DEPTH; i++) begin : g_hist
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    hist[i] <= 1'b0;
                end else if (sample_en) begin
                    if (i == 0) hist[i] <= sync_in;
                    else        hist[i] <= hist[i-1];
                end
            end
        end
    endgenerate

    // Count how many history entries hold real samples, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid <= '0;
        end else if (sample_en && valid != VW'(HIST_DEPTH)) begin
            valid <= valid + 1'b1;
        end
    end

    // Number of earlier samples that must match the current one.
    always_comb begin
        need = (mode == PQF_THREE) ? VW'(2) : VW'(1);
    end

    // Check the current sample against the required earlier samples.
    always_comb begin
        agree = (valid >= need);
        for (int i = 0; i < HIST_DEPTH; i++) begin
            if (VW'(i) < need && hist[i] != sync_in) agree = 1'b0;
        end
    end

    // Flip request only on a strobe, with no mode change, towards a new level.
    always_comb begin
        want_flip = sample_en && !clear && agree && (sync_in != cur_level);
    end

    assert_valid_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid == '0));
endmodule

// File: rtl/pqf_run_qual.sv
// Continuous qualifier: counts strobes while the input differs from the
// filtered level; any clock of agreement restarts the count.
// Assumes 1 <= RUN_STROBES < 2**CNT_W.
module pqf_run_qual #(
    parameter int CNT_W       = 4,
    parameter int RUN_STROBES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic sync_in,
    input  logic cur_level,
    input  logic clear,
    output logic want_flip
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_STROBES - 1);

    logic [CNT_W-1:0] cnt;
    logic             differ;

    // Input disagrees with the filtered level on this clock.
    always_comb begin
        differ = (sync_in != cur_level);
    end

    // Flip once the final strobe of the window arrives with the input still different.
    always_comb begin
        want_flip = !clear && differ && sample_en && (cnt == LAST);
    end

    // Advance, restart or clear the window count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !differ) begin
            cnt <= '0;
        end else if (sample_en) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    assert_agree_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in == cur_level) |=> (cnt == '0));
endmodule

// File: rtl/pqf_level.sv
// Holds the filtered level and raises one-clock edge pulses in the
// cycle the level changes. Assumes flip is a single-cycle request.
module pqf_level (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic level,
    output logic rise_pulse,
    output logic fall_pulse
);
    // Toggle the level on request and register matching edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level      <= 1'b0;
            rise_pulse <= 1'b0;
            fall_pulse <= 1'b0;
        end else begin
            level      <= level ^ flip;
            rise_pulse <= flip && !level;
            fall_pulse <= flip && level;
        end
    end

    assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_pulse, fall_pulse}));
    assert_rise_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> (level && !$past(level)));
    assert_fall_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |-> (!level && $past(level)));
endmodule

// File: rtl/pin_qual_filter.sv
// Configurable input noise filter: synchronises one pin and qualifies
// level changes by two-sample, three-sample or continuous agreement.
// Assumes sample_en comes from a prescaler in the same clock domain.
module pin_qual_filter
    import pqf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HIST_DEPTH  = 2,
    parameter int CNT_W       = 4,
    parameter int RUN_STROBES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       pin_raw,
    input  logic [1:0] mode,
    output logic       level,
    output logic       rise_pulse,
    output logic       fall_pulse
);
    logic      sync_bit;
    logic      mode_chg;
    logic      flip_smp;
    logic      flip_run;
    logic      flip;
    pqf_mode_e mode_e;
    logic [1:0] mode_q;

    assign mode_e = pqf_mode_e'(mode);

    // Remember last clock's mode to detect a switch.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 2'b00;
        else        mode_q <= mode;
    end

    // A switch of mode this clock clears all qualification state.
    always_comb begin
        mode_chg = (mode != mode_q);
    end

    pqf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (sync_bit)
    );

    pqf_sample_qual #(.HIST_DEPTH(HIST_DEPTH)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .sync_in   (sync_bit),
        .cur_level (level),
        .clear     (mode_chg),
        .mode      (mode_e),
        .want_flip (flip_smp)
    );

    pqf_run_qual #(.CNT_W(CNT_W), .RUN_STROBES(RUN_STROBES)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .sync_in   (sync_bit),
        .cur_level (level),
        .clear     (mode_chg),
        .want_flip (flip_run)
    );

    // Pick the flip request of the active mode; spare mode acts as two-sample.
    always_comb begin
        flip = (mode_e == PQF_RUN) ? flip_run : flip_smp;
    end

    pqf_level u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flip       (flip),
        .level      (level),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    assert_change_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> $past(sample_en));
    assert_mode_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (level == $past(level)));
endmodule

// File: tb/pin_qual_filter_tb_top.sv
module pin_qual_filter_tb_top;
    localparam int RUN = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0;
    logic pin_raw = 1'b0;
    logic [1:0] mode = 2'b00;
    logic level, rise_pulse, fall_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R6";
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_qual_filter #(.RUN_STROBES(RUN)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .pin_raw(pin_raw),
        .mode(mode), .level(level), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
    );

    // Reference model built from the requirements.
    logic m_s1, m_s2, m_lvl, m_rise, m_fall, m_h0, m_h1;
    logic [1:0] m_modeq;
    int m_valid, m_cnt;

    function automatic bit smp_flip(input bit chg, input bit en, input bit s,
                                    input bit h0, input bit h1, input int v,
                                    input logic [1:0] md, input bit lv);
        bit three = (md == 2'b01);
        if (chg || !en || s == lv) return 1'b0;
        if (three) return (v >= 2) && (s == h0) && (s == h1);
        return (v >= 1) && (s == h0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_lvl <= 0; m_rise <= 0; m_fall <= 0;
            m_h0 <= 0; m_h1 <= 0; m_modeq <= 0; m_valid <= 0; m_cnt <= 0;
        end else begin
            bit chg, fs, fr, f;
            chg = (mode != m_modeq);
            fs = smp_flip(chg, sample_en, m_s2, m_h0, m_h1, m_valid, mode, m_lvl);
            fr = !chg && sample_en && (m_s2 != m_lvl) && (m_cnt == RUN - 1);
            f = (mode == 2'b10) ? fr : fs;
            if (chg || m_s2 == m_lvl) m_cnt <= 0;
            else if (sample_en) m_cnt <= (m_cnt == RUN - 1) ? 0 : m_cnt + 1;
            if (chg) begin m_h0 <= 0; m_h1 <= 0; m_valid <= 0; end
            else if (sample_en) begin
                m_h1 <= m_h0; m_h0 <= m_s2;
                if (m_valid < 2) m_valid <= m_valid + 1;
            end
            m_rise <= f && !m_lvl;
            m_fall <= f && m_lvl;
            m_lvl <= m_lvl ^ f;
            m_modeq <= mode;
            m_s1 <= pin_raw; m_s2 <= m_s1;
        end
    end

    task automatic check(input string t, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        check(tag, "level", level, m_lvl);
        check(tag, "rise", rise_pulse, m_rise);
        check(tag, "fall", fall_pulse, m_fall);
    endtask

    // One clock: compare at the falling edge, then drive the next inputs.
    task automatic step(input logic p, input logic en);
        @(negedge clk);
        cmp_all();
        pin_raw = p; sample_en = en;
    endtask

    task automatic hold(input logic p, input logic en, input int n);
        for (int i = 0; i < n; i++) step(p, en);
    endtask

    initial begin
        int rises;
        void'($urandom(32'd20240611));
        // R6: reset state
        hold(1'b1, 1'b1, 4);
        check("R6", "level in reset", level, 1'b0);
        check("R6", "rise in reset", rise_pulse, 1'b0);
        check("R6", "fall in reset", fall_pulse, 1'b0);
        @(negedge clk); rst_n = 1'b1; pin_raw = 1'b0;
        hold(1'b0, 1'b1, 4);

        // R2: single-sample glitch rejected, long level accepted
        tag = "R2"; mode = 2'b00;
        hold(1'b0, 1'b1, 3);
        hold(1'b1, 1'b1, 1);
        hold(1'b0, 1'b1, 6);
        check("R2", "glitch rejected", level, 1'b0);
        rises = 0;
        for (int i = 0; i < 8; i++) begin step(1'b1, 1'b1); if (rise_pulse) rises++; end
        check("R2", "level accepted", level, 1'b1);
        check("R7", "one rise pulse", (rises == 1), 1'b1);

        // R1: synchroniser latency in two-sample mode: flip 4 edges after capture
        tag = "R1";
        hold(1'b0, 1'b1, 1);
        hold(1'b0, 1'b1, 3);
        check("R1", "not yet", level, 1'b1);
        step(1'b0, 1'b1);
        check("R1", "changed after sync", level, 1'b0);
        check("R7", "fall pulse", fall_pulse, 1'b1);
        step(1'b0, 1'b1);
        check("R7", "fall pulse one clock", fall_pulse, 1'b0);

        // R3: two agreeing samples not enough
        tag = "R3"; mode = 2'b01;
        hold(1'b0, 1'b1, 4);
        hold(1'b1, 1'b1, 2);
        hold(1'b0, 1'b1, 6);
        check("R3", "two samples rejected", level, 1'b0);
        hold(1'b1, 1'b1, 8);
        check("R3", "three samples accepted", level, 1'b1);

        // R4: continuous window one strobe short, then full
        tag = "R4"; mode = 2'b10;
        hold(1'b1, 1'b1, 4);
        hold(1'b0, 1'b1, RUN - 1);
        hold(1'b1, 1'b1, 8);
        check("R4", "short window rejected", level, 1'b1);
        hold(1'b0, 1'b1, RUN + 4);
        check("R4", "full window accepted", level, 1'b0);

        // R5: strobe low freezes qualification
        tag = "R5"; mode = 2'b00;
        hold(1'b0, 1'b1, 3);
        hold(1'b1, 1'b0, 20);
        check("R5", "no strobe no change", level, 1'b0);
        hold(1'b1, 1'b1, 6);

        // R8: mode change clears history, keeps level
        tag = "R8"; mode = 2'b01;
        hold(1'b1, 1'b1, 6);
        hold(1'b0, 1'b1, 4);
        step(1'b0, 1'b1);
        mode = 2'b00;
        step(1'b0, 1'b1);
        check("R8", "level kept over mode change", level, m_lvl);
        hold(1'b0, 1'b1, 6);

        // R9: spare mode behaves like two-sample
        tag = "R9"; mode = 2'b11;
        hold(1'b0, 1'b1, 3);
        hold(1'b1, 1'b1, 1);
        hold(1'b0, 1'b1, 5);
        check("R9", "spare glitch rejected", level, 1'b0);
        hold(1'b1, 1'b1, 6);
        check("R9", "spare accepted", level, 1'b1);

        // Random mix over all modes
        tag = "R2/R3/R4/R8 random";
        for (int seg = 0; seg < 60; seg++) begin
            int stick = 1 + ($urandom % 12);
            int rate = 1 + ($urandom % 3);
            logic p = $urandom % 2;
            mode = $urandom % 4;
            for (int c = 0; c < 300; c++) begin
                if ($urandom % stick == 0) p = ~p;
                step(p, ($urandom % rate) == 0);
            end
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule